// File: doc/BRIEF.md
# Implantation-Decay Trigger Sequencer

This block runs a circular sampling memory of 512 cells as two 256-cell halves, so that one implantation event and the decay that follows it are recorded as a linked pair. An implantation trigger starts a programmable delay. When that delay ends, the block issues a one-cycle stop-sampling command for the first half. It then waits for a decay trigger. Either the decay trigger or a programmable time-out, whichever comes first, leads to the stop command for the second half. A full-memory mode issues one stop for the whole 512-cell buffer instead. This mode suits events that need the whole depth, such as two-particle decays.

All delays and gates are 16-bit counts of the master clock tick (10 ns, which gives about 655 µs at most). A trigger is qualified by the multiplicity-valid strobe. Once an event is complete, the block holds its 2-bit type code until software acknowledges it. Triggers that arrive while a stop command is on the output are dropped, and an 8-bit saturating counter records each one.

Top module: `impdec_seq`

## Requirements
- R1: After reset, `stop_smp`, `half_sel`, `busy`, `evt_valid`, `evt_type` and `lost_cnt` are all 0. The delay, gate and mode registers reset to 0.
- R2: In the idle state, a cycle with both `imp_trig` and `mult_vld` high raises `busy`. `stop_smp` then rises with `half_sel`=0 exactly D cycles after the clock edge that sampled the trigger, where D = max(delay register, 3), so the minimum is 30 ns.
- R3: In split mode, after the first-half stop the block waits for a decay. A decay trigger (`dec_trig` and `mult_vld` high) that is sampled while the block waits produces `stop_smp` with `half_sel`=1, D cycles after its sampling edge. The event type is then 2'b01.
- R4: In split mode with gate G > 0 and no decay, the second stop (`half_sel`=1) rises G+1 cycles after the first-half stop, and the event type is 2'b10. If a decay and the time-out fall on the same edge, the decay wins.
- R5: A gate value of 0 disables the time-out, and the block waits for a decay without limit.
- R6: When bit 0 of the mode register is 1 (full-memory mode), one stop with `half_sel`=0 ends the event. The event type is 2'b00, and `evt_valid` is high in the next cycle.
- R7: Every stop pulse lasts exactly one cycle. After the last stop, `evt_valid` rises and then holds `evt_type` steady until `ack` is sampled high. The block then returns to idle and drops `busy`. Outside the completed state, `evt_type` reads 0.
- R8: While `stop_smp` is high, an implantation or decay trigger qualified by `mult_vld` is ignored. Each one adds 1 to `lost_cnt`, which saturates at 255.
- R9: A trigger without `mult_vld` has no effect. A decay trigger in idle, or an implantation trigger while an event is in progress but no stop is active, is ignored and is not counted.
- R10: A write sets a register when `cfg_we` is high: address 0 is the delay, 1 is the gate, and 2 is the mode (bit 0). A write made while `busy` is high takes effect only for the event after the return to idle.
- R11: An implantation trigger sampled on the first idle edge after an acknowledge is accepted. Qualified triggers can therefore be taken on every idle edge, well within the 40 ns multiplicity rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master tick clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address (0 delay, 1 gate, 2 mode) |
| cfg_wdata | input | 16 | Register write data |
| imp_trig | input | 1 | Implantation trigger |
| dec_trig | input | 1 | Decay trigger |
| mult_vld | input | 1 | Multiplicity-valid strobe qualifying both triggers |
| ack | input | 1 | Software acknowledge of a completed event |
| stop_smp | output | 1 | Stop-sampling command, one cycle per half |
| half_sel | output | 1 | Half being stopped: 0 first or whole, 1 second |
| evt_valid | output | 1 | Completed event awaiting acknowledge |
| evt_type | output | 2 | 00 full, 01 implant+decay, 10 implant+time-out |
| busy | output | 1 | Block is outside idle |
| lost_cnt | output | 8 | Saturating count of triggers dropped during a stop |

## Verification
The bench goes after the delay floor. A design that passes a programmed delay of 0 through as it is would stop too early, and one that counts off by one would miss the exact stop cycle. A tie between a decay and the time-out on the same edge is driven on purpose. A design that gives the time-out priority would tag the event 10 and stop at the wrong cycle. A gate write made in the middle of an event must not shorten that event's time-out, and a gate of 0 must hold the block waiting for hundreds of cycles. The bench also drives triggers into the stop cycle and more than 127 such events. A design that missed the double count, or one that wrapped past 255, would show the wrong value on `lost_cnt`.

// File: rtl/impdec_pkg.sv
package impdec_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_IMP_DLY,
      ST_STOP_A,
      ST_WAIT_DEC,
      ST_DEC_DLY,
      ST_STOP_B,
      ST_DONE
   } seq_state_t;

   localparam logic [1:0] EVT_FULL    = 2'b00;
   localparam logic [1:0] EVT_IMP_DEC = 2'b01;
   localparam logic [1:0] EVT_IMP_TMO = 2'b10;

   localparam int REG_DELAY = 0;
   localparam int REG_GATE  = 1;
   localparam int REG_MODE  = 2;
   localparam int NUM_REGS  = 3;

endpackage

// File: rtl/impdec_cfg.sv
module impdec_cfg #(
   parameter int CNT_W   = 16,
   parameter int AW      = 2,
   parameter bit FULL_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [AW-1:0]    addr,
   input  logic [CNT_W-1:0] wdata,
   input  logic             idle,
   output logic [CNT_W-1:0] dly_live,
   output logic [CNT_W-1:0] gate_live,
   output logic             full_live
);
   import impdec_pkg::*;

   logic [NUM_REGS-1:0][CNT_W-1:0] live;

   // Each register has a software-written copy and a copy frozen for the running event.
   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      logic [CNT_W-1:0] shd_q;
      logic [CNT_W-1:0] hold_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            shd_q <= '0;
         end else if (we && (addr == AW'(i))) begin
            shd_q <= wdata;
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            hold_q <= '0;
         end else if (idle) begin
            hold_q <= shd_q;
         end
      end

      assign live[i] = idle ? shd_q : hold_q;
   end

   assign dly_live  = live[REG_DELAY];
   assign gate_live = live[REG_GATE];

   if (FULL_EN) begin : g_full
      assign full_live = live[REG_MODE][0];
   end else begin : g_nofull
      assign full_live = 1'b0;
   end

endmodule

// File: rtl/impdec_cnt.sv
module impdec_cnt #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         en,
   output logic         hit
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (en && (cnt_q != '0)) begin
         cnt_q <= cnt_q - W'(1);
      end
   end

   // A loaded value of zero never reaches one, so it never expires.
   assign hit = (cnt_q == W'(1));

endmodule

// File: rtl/impdec_lost.sv
module impdec_lost #(
   parameter int W   = 8,
   parameter bit SAT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [1:0]   inc,
   output logic [W-1:0] cnt
);
   localparam logic [W:0] MAX_V = {1'b0, {W{1'b1}}};

   logic [W:0]   sum;
   logic [W-1:0] nxt;

   assign sum = {1'b0, cnt} + {{(W-1){1'b0}}, inc};

   if (SAT) begin : g_sat
      assign nxt = (sum > MAX_V) ? MAX_V[W-1:0] : sum[W-1:0];
   end else begin : g_wrap
      assign nxt = sum[W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else begin
         cnt <= nxt;
      end
   end

endmodule

// File: rtl/impdec_seq.sv
module impdec_seq #(
   parameter int CNT_W   = 16,
   parameter int AW      = 2,
   parameter int LOST_W  = 8,
   parameter int MIN_DLY = 3,
   parameter bit FULL_EN = 1'b1,
   parameter bit LOST_SAT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [AW-1:0]     cfg_addr,
   input  logic [CNT_W-1:0]  cfg_wdata,
   input  logic              imp_trig,
   input  logic              dec_trig,
   input  logic              mult_vld,
   input  logic              ack,
   output logic              stop_smp,
   output logic              half_sel,
   output logic              evt_valid,
   output logic [1:0]        evt_type,
   output logic              busy,
   output logic [LOST_W-1:0] lost_cnt
);
   import impdec_pkg::*;

   localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_DLY);

   if (CNT_W < 4) begin : g_bad_w
      $error("impdec_seq: CNT_W must be at least 4");
   end
   if ((1 << AW) < NUM_REGS) begin : g_bad_aw
      $error("impdec_seq: AW too small for the register set");
   end
   if (MIN_DLY < 2 || MIN_DLY >= (1 << CNT_W)) begin : g_bad_min
      $error("impdec_seq: MIN_DLY out of range");
   end

   seq_state_t       st_q, st_nxt;
   logic [1:0]       typ_q, typ_nxt;
   logic             idle;
   logic [CNT_W-1:0] dly_live, gate_live, eff_dly;
   logic             full_live;
   logic             imp_ok, dec_ok;
   logic             cnt_load, cnt_en, cnt_hit;
   logic [CNT_W-1:0] cnt_val;
   logic [1:0]       lost_inc;

   assign idle   = (st_q == ST_IDLE);
   assign imp_ok = imp_trig & mult_vld;
   assign dec_ok = dec_trig & mult_vld;

   impdec_cfg #(.CNT_W(CNT_W), .AW(AW), .FULL_EN(FULL_EN)) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (cfg_we),
      .addr      (cfg_addr),
      .wdata     (cfg_wdata),
      .idle      (idle),
      .dly_live  (dly_live),
      .gate_live (gate_live),
      .full_live (full_live)
   );

   assign eff_dly = (dly_live < MIN_V) ? MIN_V : dly_live;

   impdec_cnt #(.W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cnt_load),
      .load_val (cnt_val),
      .en       (cnt_en),
      .hit      (cnt_hit)
   );

   always_comb begin
      st_nxt   = st_q;
      typ_nxt  = typ_q;
      cnt_load = 1'b0;
      cnt_val  = '0;
      cnt_en   = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (imp_ok) begin
               st_nxt   = ST_IMP_DLY;
               cnt_load = 1'b1;
               cnt_val  = eff_dly;
            end
         end
         ST_IMP_DLY: begin
            cnt_en = 1'b1;
            if (cnt_hit) st_nxt = ST_STOP_A;
         end
         ST_STOP_A: begin
            if (full_live) begin
               st_nxt  = ST_DONE;
               typ_nxt = EVT_FULL;
            end else begin
               st_nxt   = ST_WAIT_DEC;
               cnt_load = 1'b1;
               cnt_val  = gate_live;
            end
         end
         ST_WAIT_DEC: begin
            cnt_en = 1'b1;
            if (dec_ok) begin
               st_nxt   = ST_DEC_DLY;
               typ_nxt  = EVT_IMP_DEC;
               cnt_load = 1'b1;
               cnt_val  = eff_dly;
            end else if (cnt_hit) begin
               st_nxt  = ST_STOP_B;
               typ_nxt = EVT_IMP_TMO;
            end
         end
         ST_DEC_DLY: begin
            cnt_en = 1'b1;
            if (cnt_hit) st_nxt = ST_STOP_B;
         end
         ST_STOP_B: st_nxt = ST_DONE;
         ST_DONE:   if (ack) st_nxt = ST_IDLE;
         default:   st_nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         typ_q <= EVT_FULL;
      end else begin
         st_q  <= st_nxt;
         typ_q <= typ_nxt;
      end
   end

   assign stop_smp  = (st_q == ST_STOP_A) || (st_q == ST_STOP_B);
   assign half_sel  = (st_q == ST_STOP_B);
   assign evt_valid = (st_q == ST_DONE);
   assign evt_type  = evt_valid ? typ_q : 2'b00;
   assign busy      = !idle;

   assign lost_inc = stop_smp ? ({1'b0, imp_ok} + {1'b0, dec_ok}) : 2'b00;

   impdec_lost #(.W(LOST_W), .SAT(LOST_SAT)) u_lost (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (lost_inc),
      .cnt   (lost_cnt)
   );

endmodule

// File: rtl/impdec_seq_chk.sv
module impdec_seq_chk #(
   parameter int LOST_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ack,
   input logic              stop_smp,
   input logic              half_sel,
   input logic              evt_valid,
   input logic [1:0]        evt_type,
   input logic              busy,
   input logic [LOST_W-1:0] lost_cnt
);
   localparam logic [LOST_W-1:0] LMAX = {LOST_W{1'b1}};

   AST_STOP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      stop_smp |=> !stop_smp); // R7
   AST_STOP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_smp || evt_valid) |-> busy); // R2
   AST_SECOND_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_smp && half_sel) |=> evt_valid); // R3
   AST_TYPE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid |-> (evt_type != 2'b11)); // R4
   AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && !ack) |=> (evt_valid && $stable(evt_type))); // R7
   AST_ACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && ack) |=> !busy); // R7
   AST_LOST_MONO: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (lost_cnt >= $past(lost_cnt))); // R8
   AST_LOST_SAT: assert property (@(posedge clk) disable iff (!rst_n)
      (lost_cnt == LMAX) |=> (lost_cnt == LMAX)); // R8
   AST_LOST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !stop_smp |=> $stable(lost_cnt)); // R9

endmodule

bind impdec_seq impdec_seq_chk #(.LOST_W(LOST_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ack       (ack),
   .stop_smp  (stop_smp),
   .half_sel  (half_sel),
   .evt_valid (evt_valid),
   .evt_type  (evt_type),
   .busy      (busy),
   .lost_cnt  (lost_cnt)
);

// File: tb/impdec_seq_test.sv
module impdec_seq_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_addr = '0;
   logic [15:0] cfg_wdata = '0;
   logic        imp_trig = 1'b0, dec_trig = 1'b0, mult_vld = 1'b0, ack = 1'b0;
   logic        stop_smp, half_sel, evt_valid, busy;
   logic [1:0]  evt_type;
   logic [7:0]  lost_cnt;

   int nvec = 0, nerr = 0;
   int m_dly = 0, m_gate = 0, m_full = 0, m_lost = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   impdec_seq uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .imp_trig(imp_trig), .dec_trig(dec_trig),
      .mult_vld(mult_vld), .ack(ack), .stop_smp(stop_smp), .half_sel(half_sel),
      .evt_valid(evt_valid), .evt_type(evt_type), .busy(busy), .lost_cnt(lost_cnt)
   );

   function automatic int eff_d(input int d);
      return (d < 3) ? 3 : d;
   endfunction

   function automatic int gap_b(input int g, input int t, input int d);
      return (t >= 0) ? (t + 2 + eff_d(d)) : (g + 1);
   endfunction

   function automatic int sat_add(input int a, input int b);
      return (a + b > 255) ? 255 : a + b;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nvec++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wr(input int a, input int v);
      cfg_we = 1'b1; cfg_addr = 2'(a); cfg_wdata = 16'(v);
      @(negedge clk);
      cfg_we = 1'b0;
      if (a == 0) m_dly = v; else if (a == 1) m_gate = v; else if (a == 2) m_full = v & 1;
   endtask

   // t_dec < 0 selects the time-out path; starts and ends just after a negedge
   task automatic run_event(input int t_dec, input bit inject, input bit noise,
                            input bit mid_wr, input int mid_val);
      int sd, sg, sf, j;
      sd = m_dly; sg = m_gate; sf = m_full;
      imp_trig = 1'b1; mult_vld = 1'b1;
      @(negedge clk);
      imp_trig = 1'b0; mult_vld = 1'b0;
      chk(busy == 1'b1, "R2 busy", int'(busy), 1);
      j = 0;
      while (!stop_smp && j < 70000) begin
         @(negedge clk); j++;
      end
      chk(j == eff_d(sd), "R2 first stop cycle", j, eff_d(sd));
      chk(half_sel == 1'b0, "R2 first half", int'(half_sel), 0);
      if (inject) begin
         imp_trig = 1'b1; dec_trig = 1'b1; mult_vld = 1'b1;
         m_lost = sat_add(m_lost, 2);
      end
      @(negedge clk);
      imp_trig = 1'b0; dec_trig = 1'b0; mult_vld = 1'b0;
      chk(stop_smp == 1'b0, "R7 stop one cycle", int'(stop_smp), 0);
      if (sf != 0) begin
         chk(evt_valid && evt_type == 2'b00, "R6 full type", int'(evt_type), 0);
      end else begin
         j = 1;
         while (!stop_smp && j < 70000) begin
            if (mid_wr && j == 1) begin
               cfg_we = 1'b1; cfg_addr = 2'd1; cfg_wdata = 16'(mid_val);
            end
            if (noise) begin
               imp_trig = 1'b1; mult_vld = 1'b1;
            end
            if (t_dec >= 0 && j == t_dec + 1) begin
               dec_trig = 1'b1; mult_vld = 1'b1;
            end
            @(negedge clk);
            cfg_we = 1'b0; imp_trig = 1'b0; dec_trig = 1'b0; mult_vld = 1'b0;
            j++;
         end
         if (mid_wr) m_gate = mid_val;
         if (t_dec >= 0)
            chk(j == gap_b(sg, t_dec, sd), "R3 decay stop gap", j, gap_b(sg, t_dec, sd));
         else
            chk(j == gap_b(sg, t_dec, sd), "R4 timeout stop gap", j, gap_b(sg, t_dec, sd));
         chk(half_sel == 1'b1, "R3 second half", int'(half_sel), 1);
         @(negedge clk);
         chk(evt_valid && evt_type == ((t_dec >= 0) ? 2'b01 : 2'b10), "R4 event type",
             int'(evt_type), (t_dec >= 0) ? 1 : 2);
      end
      chk(lost_cnt == 8'(m_lost), "R8 lost count", int'(lost_cnt), m_lost);
      @(negedge clk);
      chk(evt_valid == 1'b1, "R7 done held", int'(evt_valid), 1);
      ack = 1'b1;
      @(negedge clk);
      ack = 1'b0;
      chk(!busy && !evt_valid && evt_type == 2'b00, "R7 ack to idle", int'(busy), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         nerr++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!stop_smp && !half_sel && !busy && !evt_valid && evt_type == 2'b00 && lost_cnt == 8'd0,
          "R1 reset outputs", int'(busy), 0);

      // R9: triggers without qualifier, decay in idle
      imp_trig = 1'b1;
      repeat (4) @(negedge clk);
      imp_trig = 1'b0; dec_trig = 1'b1; mult_vld = 1'b1;
      repeat (3) @(negedge clk);
      dec_trig = 1'b0; mult_vld = 1'b0;
      chk(!busy && lost_cnt == 8'd0, "R9 unqualified ignored", int'(busy), 0);

      // R2 with reset-value delay 0 -> floor of 3, R4 timeout
      wr(1, 6);
      run_event(-1, 1'b0, 1'b0, 1'b0, 0);
      // R11 back-to-back after acknowledge, R3 decay
      run_event(2, 1'b0, 1'b0, 1'b0, 0);
      // R4 tie: decay on the time-out edge wins
      wr(0, 7); wr(1, 9);
      run_event(8, 1'b0, 1'b0, 1'b0, 0);
      // R8 injected triggers during stop, R9 implant noise while waiting
      run_event(-1, 1'b1, 1'b1, 1'b0, 0);
      // R10 gate write mid-event deferred, then applied
      wr(1, 20);
      run_event(-1, 1'b0, 1'b0, 1'b1, 4);
      run_event(-1, 1'b0, 1'b0, 1'b0, 0);
      // R5 gate zero waits indefinitely
      wr(1, 0); wr(0, 5);
      run_event(300, 1'b0, 1'b0, 1'b0, 0);
      // R6 full-memory mode
      wr(2, 1);
      run_event(-1, 1'b1, 1'b0, 1'b0, 0);
      wr(2, 0);

      // constrained random events
      for (int n = 0; n < 40; n++) begin
         int g, t;
         wr(0, $urandom_range(0, 12));
         g = $urandom_range(0, 20);
         wr(1, g);
         wr(2, ($urandom_range(0, 3) == 0) ? 1 : 0);
         if (g == 0) t = $urandom_range(0, 40);
         else if ($urandom_range(0, 1) == 1) t = $urandom_range(0, g - 1);
         else t = -1;
         run_event(t, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                   1'($urandom_range(0, 3) == 0), $urandom_range(1, 20));
      end

      // R8 saturation
      wr(0, 0); wr(1, 1); wr(2, 0);
      for (int n = 0; n < 130; n++) run_event(-1, 1'b1, 1'b0, 1'b0, 0);
      chk(lost_cnt == 8'd255, "R8 saturation", int'(lost_cnt), 255);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end

endmodule